// File: doc/BRIEF.md
# Level-Priority Interrupt Arbiter

This block collects interrupt requests from two controller instances and hands the processor core the most urgent request level. Each controller has 56 programmable sources, numbered 8 to 63. Software gives each source a level from 1 to 7 and a priority from 0 to 7 inside that level, where 7 is the most urgent. Controller 0 also takes seven fixed external request lines. Line n belongs to level n, and its rank sits between the programmable priorities 4 and 3 of that level. A mask bit for each source, plus a mask-all bit for each controller, keep requests away from the core.

A higher level always wins over a lower one. Inside a level, the unmasked pending source with the highest rank wins. The block presents the winning level on a registered output. During an acknowledge cycle, software reads back the winning vector. It can read it per level from one controller, or per level from all controllers together. A software acknowledge read gives the overall winner of one controller. Configuration, masks and acknowledges all share a small register read/write port. Input conditioning of the external pins, the bus fabric and exception handling are outside this block.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, `irq_lvl_o` is 0, `rd_data` is 0, every mask bit is 1 (masked), and every source configuration reads 0.
- R2: Writing address n (8 to 63) of a controller stores level in wdata[5:3] and priority in wdata[2:0], and the entry reads back the same way. Writes to addresses 0 to 7 are ignored, and those addresses read 0.
- R3: `irq_lvl_o` is the highest level holding an unmasked pending source across all controllers that are not mask-all, or 0 if there is none. It is registered and changes one clock after the change in pending or mask state.
- R4: Mask bits sit at address 0x40 (sources 0 to 31) and address 0x41 (sources 32 to 63). A 1 excludes the source. In controller 0, mask bit n (1 to 7) masks external line n.
- R5: Writing 1 to wdata[0] at address 0x42 sets a controller's mask-all bit. This drops the controller's contribution to `irq_lvl_o` to 0. Pending state and acknowledge results stay as they are, and clearing the bit restores the level.
- R6: A local read at address 0x50+L (L = 1 to 7) returns the vector of the winning source at level L. A programmable source n has vector 64+n, and sources at other levels do not affect the result.
- R7: External line n has vector 24+n. At level n it beats programmable priorities 0 to 3 and loses to priorities 4 to 7.
- R8: When two programmable sources have the same level and priority, the lower source number wins.
- R9: An acknowledge read finds no winner returns the spurious vector 0x18 (24).
- R10: A local read at address 0x50 returns the controller's overall winner: the winner of its highest pending level. A global read at any address other than 0x51 to 0x57 returns 0.
- R11: A global read (`rd_global`=1) at 0x50+L returns the winner at level L across all controllers. An equal rank goes to the lower controller number.
- R12: A source configured with level 0 never wins and never raises the output level.
- R13: `rd_data` shows the read result one clock after the cycle in which `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ctrl | input | 1 | Controller targeted by the write |
| reg_addr | input | 7 | Write address |
| reg_wdata | input | 32 | Write data |
| src_req_i | input | 112 | Pending programmable requests; bit c*56+(n-8) is source n of controller c |
| ext_req_i | input | 7 (7:1) | External request lines, bit n is line n, attached to controller 0 |
| rd_en | input | 1 | Read strobe |
| rd_global | input | 1 | 1 selects a global acknowledge read across controllers |
| rd_ctrl | input | 1 | Controller for a local read |
| rd_addr | input | 7 | Read address |
| rd_data | output | 32 | Registered read result |
| irq_lvl_o | output | 3 | Registered request level to the core |

## Verification
The bench drives all inputs on the falling edge. Read results are due at the first rising edge after `rd_en` is high. The level output is due at the first rising edge after a change in pending input, but only at the second edge after a mask write, because the mask register takes one edge itself. The read driver pushes the expected vector into a queue, and a monitor pops it just after that rising edge. Level checks sample just after the edge as well. After a mask write they also confirm that the old level still holds at the falling edge between the two rising edges.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 3;
  localparam int PRI_W   = 3;
  localparam int KEY_W   = PRI_W + 1;
  localparam int VEC_W   = 8;
  localparam int NUM_LVL = (1 << LVL_W) - 1;

  localparam logic [VEC_W-1:0] VEC_SPUR      = 8'h18;
  localparam logic [VEC_W-1:0] VEC_EXT_BASE  = 8'd24;
  localparam logic [VEC_W-1:0] VEC_PROG_BASE = 8'd64;
  // external lines rank between priority 4 (key 8) and 3 (key 6)
  localparam logic [KEY_W-1:0] KEY_EXT       = 4'd7;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [PRI_W-1:0] pri;
  } src_cfg_t;

  typedef struct packed {
    logic             hit;
    logic [KEY_W-1:0] key;
    logic [VEC_W-1:0] vec;
  } pick_t;

  function automatic logic [KEY_W-1:0] prog_key(input logic [PRI_W-1:0] pri);
    return {pri, 1'b0};
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int FIRST_PROG = 8,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output src_cfg_t [NUM_SRC-1:0]      cfg_o,
  output logic [NUM_SRC-1:0]          mask_o,
  output logic                        mask_all_o
);
  localparam int CFG_W         = $bits(src_cfg_t);
  localparam int MASK_WORDS    = NUM_SRC / DATA_W;
  localparam int MASK_BASE     = NUM_SRC;
  localparam int MASK_ALL_ADDR = NUM_SRC + MASK_WORDS;

  src_cfg_t [NUM_SRC-1:0] cfg_q;
  logic [NUM_SRC-1:0]     mask_q;
  logic                   mask_all_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      mask_q     <= '1;
      mask_all_q <= 1'b0;
    end else if (we_i) begin
      for (int i = FIRST_PROG; i < NUM_SRC; i++) begin
        if (addr_i == ADDR_W'(i)) cfg_q[i] <= src_cfg_t'(wdata_i[CFG_W-1:0]);
      end
      for (int w = 0; w < MASK_WORDS; w++) begin
        if (addr_i == ADDR_W'(MASK_BASE + w)) mask_q[w*DATA_W +: DATA_W] <= wdata_i;
      end
      if (addr_i == ADDR_W'(MASK_ALL_ADDR)) mask_all_q <= wdata_i[0];
    end
  end

  assign cfg_o      = cfg_q;
  assign mask_o     = mask_q;
  assign mask_all_o = mask_all_q;
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LEVEL   = 1
) (
  input  src_cfg_t [NUM_SRC-1:0] cfg_i,
  input  logic [NUM_SRC-1:0]     active_i,
  input  logic                   ext_i,
  output pick_t                  pick_o
);
  always_comb begin
    pick_o     = '0;
    pick_o.vec = VEC_SPUR;
    // ascending scan with strict compare: lower index keeps a tie
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active_i[i] && cfg_i[i].lvl == LVL_W'(LEVEL) &&
          (!pick_o.hit || prog_key(cfg_i[i].pri) > pick_o.key)) begin
        pick_o.hit = 1'b1;
        pick_o.key = prog_key(cfg_i[i].pri);
        pick_o.vec = VEC_PROG_BASE + VEC_W'(i);
      end
    end
    if (ext_i && (!pick_o.hit || KEY_EXT > pick_o.key)) begin
      pick_o.hit = 1'b1;
      pick_o.key = KEY_EXT;
      pick_o.vec = VEC_EXT_BASE + VEC_W'(LEVEL);
    end
  end
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC    = 64,
  parameter int FIRST_PROG = 8,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int ACK_BASE   = 80
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_SRC-FIRST_PROG-1:0]  req_i,
  input  logic [NUM_LVL:1]               ext_req_i,
  input  logic [ADDR_W-1:0]              raddr_i,
  output pick_t [NUM_LVL:1]              picks_o,
  output logic [LVL_W-1:0]               lvl_o,
  output logic                           mask_all_o,
  output logic [DATA_W-1:0]              rdata_o
);
  localparam int CFG_W         = $bits(src_cfg_t);
  localparam int MASK_WORDS    = NUM_SRC / DATA_W;
  localparam int MASK_ALL_ADDR = NUM_SRC + MASK_WORDS;

  src_cfg_t [NUM_SRC-1:0] cfg;
  logic [NUM_SRC-1:0]     mask;
  logic                   mask_all;
  logic [NUM_SRC-1:0]     pending;
  logic [NUM_SRC-1:0]     active;
  logic [NUM_LVL:1]       ext_active;
  logic [LVL_W-1:0]       top_lvl;
  logic [VEC_W-1:0]       sw_vec;

  irq_cfg_regs #(
    .NUM_SRC(NUM_SRC), .FIRST_PROG(FIRST_PROG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we_i(we_i), .addr_i(waddr_i), .wdata_i(wdata_i),
    .cfg_o(cfg), .mask_o(mask), .mask_all_o(mask_all)
  );

  assign pending    = {req_i, {FIRST_PROG{1'b0}}};
  assign active     = pending & ~mask;
  assign ext_active = ext_req_i & ~mask[NUM_LVL:1];

  for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
    irq_level_pick #(.NUM_SRC(NUM_SRC), .LEVEL(l)) u_pick (
      .cfg_i(cfg), .active_i(active), .ext_i(ext_active[l]), .pick_o(picks_o[l])
    );
  end

  always_comb begin
    top_lvl = '0;
    sw_vec  = VEC_SPUR;
    for (int l = 1; l <= NUM_LVL; l++) begin
      if (picks_o[l].hit) begin
        top_lvl = LVL_W'(l);
        sw_vec  = picks_o[l].vec;
      end
    end
  end

  assign lvl_o      = mask_all ? '0 : top_lvl;
  assign mask_all_o = mask_all;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (raddr_i == ADDR_W'(i)) rdata_o = DATA_W'(cfg[i]);
    end
    for (int w = 0; w < MASK_WORDS; w++) begin
      if (raddr_i == ADDR_W'(NUM_SRC + w)) rdata_o = mask[w*DATA_W +: DATA_W];
    end
    if (raddr_i == ADDR_W'(MASK_ALL_ADDR)) rdata_o = DATA_W'(mask_all);
    if (raddr_i == ADDR_W'(ACK_BASE))      rdata_o = DATA_W'(sw_vec);
    for (int l = 1; l <= NUM_LVL; l++) begin
      if (raddr_i == ADDR_W'(ACK_BASE + l)) rdata_o = DATA_W'(picks_o[l].vec);
    end
  end

  logic unused_cfg_w;
  assign unused_cfg_w = (CFG_W == 0);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_CTRL   = 2,
  parameter int NUM_SRC    = 64,
  parameter int FIRST_PROG = 8,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CTRL_W     = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
  parameter int NUM_PROG   = NUM_SRC - FIRST_PROG
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic [CTRL_W-1:0]            reg_ctrl,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  input  logic [NUM_CTRL*NUM_PROG-1:0] src_req_i,
  input  logic [NUM_LVL:1]             ext_req_i,
  input  logic                         rd_en,
  input  logic                         rd_global,
  input  logic [CTRL_W-1:0]            rd_ctrl,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [LVL_W-1:0]             irq_lvl_o
);
  localparam int ACK_BASE = NUM_SRC + 16;

  pick_t [NUM_CTRL-1:0][NUM_LVL:1] picks;
  logic  [NUM_CTRL-1:0][LVL_W-1:0] ctrl_lvl;
  logic  [NUM_CTRL-1:0][DATA_W-1:0] ctrl_rdata;
  logic  [NUM_CTRL-1:0]            mask_all_vec;
  logic  [NUM_LVL:1][VEC_W-1:0]    glob_vec;
  logic  [LVL_W-1:0]               next_lvl;
  logic  [DATA_W-1:0]              rd_mux;

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    logic [NUM_LVL:1] ext_c;
    if (c == 0) begin : g_ext
      assign ext_c = ext_req_i;
    end else begin : g_noext
      assign ext_c = '0;
    end
    irq_ctrl_unit #(
      .NUM_SRC(NUM_SRC), .FIRST_PROG(FIRST_PROG), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .ACK_BASE(ACK_BASE)
    ) u_ctrl (
      .clk(clk), .rst(rst),
      .we_i(reg_we && reg_ctrl == CTRL_W'(c)),
      .waddr_i(reg_addr), .wdata_i(reg_wdata),
      .req_i(src_req_i[c*NUM_PROG +: NUM_PROG]),
      .ext_req_i(ext_c), .raddr_i(rd_addr),
      .picks_o(picks[c]), .lvl_o(ctrl_lvl[c]),
      .mask_all_o(mask_all_vec[c]), .rdata_o(ctrl_rdata[c])
    );
  end

  // cross-controller merge per level; strict compare keeps lower controller on a tie
  always_comb begin
    for (int l = 1; l <= NUM_LVL; l++) begin
      logic             hit;
      logic [KEY_W-1:0] key;
      hit = 1'b0;
      key = '0;
      glob_vec[l] = VEC_SPUR;
      for (int c = 0; c < NUM_CTRL; c++) begin
        if (picks[c][l].hit && (!hit || picks[c][l].key > key)) begin
          hit = 1'b1;
          key = picks[c][l].key;
          glob_vec[l] = picks[c][l].vec;
        end
      end
    end
  end

  always_comb begin
    next_lvl = '0;
    for (int c = 0; c < NUM_CTRL; c++) begin
      if (ctrl_lvl[c] > next_lvl) next_lvl = ctrl_lvl[c];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_global) begin
      for (int l = 1; l <= NUM_LVL; l++) begin
        if (rd_addr == ADDR_W'(ACK_BASE + l)) rd_mux = DATA_W'(glob_vec[l]);
      end
    end else begin
      for (int c = 0; c < NUM_CTRL; c++) begin
        if (rd_ctrl == CTRL_W'(c)) rd_mux = ctrl_rdata[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lvl_o <= '0;
      rd_data   <= '0;
    end else begin
      irq_lvl_o <= next_lvl;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int NUM_CTRL = 2,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int NUM_SRC  = 64,
  parameter int WIDTH_RQ = 112
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic                rd_global,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [DATA_W-1:0]   rd_data,
  input logic [2:0]          irq_lvl_o,
  input logic [WIDTH_RQ-1:0] src_req_i,
  input logic [7:1]          ext_req_i,
  input logic [NUM_CTRL-1:0] mask_all_vec
);
  localparam int ACK_LO = NUM_SRC + 17;
  localparam int ACK_HI = NUM_SRC + 23;

  logic ack_addr;
  assign ack_addr = (rd_addr >= ADDR_W'(ACK_LO)) && (rd_addr <= ADDR_W'(ACK_HI));

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (irq_lvl_o == 3'd0 && rd_data == '0));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
    $past(src_req_i == '0 && ext_req_i == '0) |-> irq_lvl_o == 3'd0);

  assert_mask_all_R5: assert property (@(posedge clk) disable iff (rst)
    $past(&mask_all_vec) |-> irq_lvl_o == 3'd0);

  assert_ack_vector_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && ack_addr) |->
      (rd_data == 32'd24 || (rd_data >= 32'd25 && rd_data <= 32'd31) ||
       (rd_data >= 32'd72 && rd_data <= 32'd127)));

  assert_global_other_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && rd_global && !ack_addr) |-> rd_data == '0);

  assert_reserved_cfg_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !rd_global && rd_addr < ADDR_W'(8)) |-> rd_data == '0);

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    $past(!rd_en) |-> $stable(rd_data));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .NUM_SRC(NUM_SRC), .WIDTH_RQ(NUM_CTRL*NUM_PROG)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_global(rd_global), .rd_addr(rd_addr),
  .rd_data(rd_data), .irq_lvl_o(irq_lvl_o), .src_req_i(src_req_i),
  .ext_req_i(ext_req_i), .mask_all_vec(mask_all_vec)
);

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG      = 56;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [0:0]  reg_ctrl;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [2*NPROG-1:0] src_req_i;
  logic [7:1]  ext_req_i;
  logic        rd_en, rd_global;
  logic [0:0]  rd_ctrl;
  logic [6:0]  rd_addr;
  logic [31:0] rd_data;
  logic [2:0]  irq_lvl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_arbiter u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ctrl(reg_ctrl), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .src_req_i(src_req_i), .ext_req_i(ext_req_i),
    .rd_en(rd_en), .rd_global(rd_global), .rd_ctrl(rd_ctrl), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_lvl_o(irq_lvl_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int c, input int addr, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ctrl = 1'(c); reg_addr = 7'(addr); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_expect(input int c, input bit glob, input int addr, input int exp,
                           input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_global = glob; rd_ctrl = 1'(c); rd_addr = 7'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_src(input int c, input int n, input logic v);
    @(negedge clk);
    src_req_i[c*NPROG + n - 8] = v;
  endtask

  task automatic level_due(input int exp, input string tag);
    @(posedge clk);
    #1 check(int'(irq_lvl_o), exp, tag);
  endtask

  // monitor: result of a read is due just after the edge that sees rd_en
  always @(posedge clk) begin
    if (rd_en) begin
      #1;
      if (exp_q.size() == 0) begin
        check(1, 0, "R13 unexpected read");
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(rd_data), e, t);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reg_we = 0; reg_ctrl = 0; reg_addr = 0; reg_wdata = 0;
    src_req_i = '0; ext_req_i = '0; rd_en = 0; rd_global = 0; rd_ctrl = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(int'(irq_lvl_o), 0, "R1 level");
    check(int'(rd_data), 0, "R1 rd_data");
    rd_expect(0, 0, 'h40, 32'hFFFF_FFFF, "R1 mask lo");
    rd_expect(1, 0, 'h41, 32'hFFFF_FFFF, "R1 mask hi");
    rd_expect(0, 0, 10, 0, "R1 cfg");

    // R2 configuration storage
    wr(0, 10, 32'h1A);                          // level 3, prio 2
    rd_expect(0, 0, 10, 'h1A, "R2 readback");
    wr(0, 5, 32'h3F);
    rd_expect(0, 0, 5, 0, "R2 reserved");

    // R4 mask then R3 latency
    set_src(0, 10, 1'b1);
    level_due(0, "R4 masked");
    wr(0, 'h40, ~(32'h1 << 10));
    check(int'(irq_lvl_o), 0, "R3 old level held");
    level_due(3, "R3 level after mask");
    rd_expect(0, 0, 'h53, 74, "R6 single");

    // R6/R7/R8 ranking inside level 3
    wr(0, 20, 32'h1E);                          // level 3, prio 6
    set_src(0, 20, 1'b1);
    wr(0, 'h40, ~((32'h1 << 10) | (32'h1 << 20) | (32'h1 << 3)));
    rd_expect(0, 0, 'h53, 84, "R6 higher prio");
    @(negedge clk) ext_req_i[3] = 1'b1;
    rd_expect(0, 0, 'h53, 84, "R7 prio6 over ext");
    wr(0, 20, 32'h1C);                          // prio 4
    rd_expect(0, 0, 'h53, 84, "R7 prio4 over ext");
    wr(0, 20, 32'h1A);                          // prio 2
    rd_expect(0, 0, 'h53, 27, "R7 ext over prio2");
    @(negedge clk) ext_req_i[3] = 1'b0;
    rd_expect(0, 0, 'h53, 74, "R8 tie lower number");
    rd_expect(0, 0, 'h55, 24, "R9 spurious");

    // R10 software acknowledge
    wr(0, 30, 32'h30);                          // level 6, prio 0
    wr(0, 'h40, ~((32'h1 << 10) | (32'h1 << 20) | (32'h1 << 30) | (32'h1 << 3)));
    set_src(0, 30, 1'b1);
    level_due(6, "R3 level 6");
    rd_expect(0, 0, 'h50, 94, "R10 sw ack");
    rd_expect(0, 1, 'h50, 0, "R10 global sw");

    // R12 level-0 source
    wr(0, 40, 32'h07);
    wr(0, 'h41, ~(32'h1 << 8));
    set_src(0, 40, 1'b1);
    rd_expect(0, 0, 'h50, 94, "R12 sw ack");
    rd_expect(0, 0, 'h57, 24, "R12 level7 empty");
    level_due(6, "R12 level");

    // R5 mask-all
    wr(0, 'h42, 32'h1);
    check(int'(irq_lvl_o), 6, "R5 old level held");
    level_due(0, "R5 forced zero");
    rd_expect(0, 0, 'h56, 94, "R5 pending kept");
    rd_expect(0, 0, 'h42, 1, "R5 readback");
    wr(0, 'h42, 32'h0);
    level_due(6, "R5 restored");

    // R11 global acknowledge
    wr(1, 12, 32'h35);                          // level 6, prio 5
    wr(1, 'h40, ~(32'h1 << 12));
    set_src(1, 12, 1'b1);
    rd_expect(0, 1, 'h56, 76, "R11 ctrl1 wins");
    rd_expect(1, 0, 'h56, 76, "R6 ctrl1 local");
    wr(0, 30, 32'h35);
    rd_expect(0, 1, 'h56, 94, "R11 tie ctrl0");

    // R3 across controllers
    wr(1, 50, 32'h38);
    wr(1, 'h41, ~(32'h1 << 18));
    set_src(1, 50, 1'b1);
    level_due(7, "R3 ctrl1 level 7");
    rd_expect(1, 1, 'h57, 114, "R11 global level 7");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule